// File: doc/BRIEF.md
# Real-Time Tick Counter with Coherent Byte-Wise Readout

This block keeps a 40-bit real-time count that advances on ticks taken from an oscillator pulse. A prescaler can sit in that path. Software reads the count through a byte-wide register port. A transaction marker loads a start address, each read strobe returns one byte and steps the address, and an end marker closes the transaction. The counter's top byte lives at address 0xC6, and the lower bytes follow at rising addresses.

Reading the top byte freezes the visible count for the rest of the transaction, so the five bytes always belong to one value. Ticks that arrive while the count is frozen land in a 6-bit backup counter. That width comes from 1 ms of ticks at 32768 Hz, which is 33 ticks. When the transaction ends, the backup total and any tick of that same cycle are added to the count in a single cycle. If the backup would pass its ceiling, it saturates and raises a sticky flag.

The lock is armed only by an actual read strobe at the top byte. A transaction that only sets the address to 0xC5 does not freeze anything. A burst that starts at 0xC5 locks and releases inside that one transaction.

Top module: `rtc_burst_counter`

## Requirements
- R1: After reset the count, the backup counter, the lock, `ovf_o` and `rdata_o` are all zero.
- R2: While unlocked and with the prescaler disabled, each clock cycle with `osc_i` high adds exactly one to the count.
- R3: `txn_start_i` loads the byte pointer from `addr_i`. Each `rd_i` steps the pointer by one. `rdata_o` is registered and shows the addressed byte in the cycle after the strobe. Address 0xC6 holds count bits 39:32, 0xC7 bits 31:24, 0xC8 bits 23:16, 0xC9 bits 15:8 and 0xCA bits 7:0.
- R4: A read strobe while the pointer is 0xC6 freezes the count from that cycle until the end marker. A tick in the strobe cycle, or in any frozen cycle, goes to the backup counter instead of the count.
- R5: In the cycle with `txn_end_i`, the count grows by the backup total plus that cycle's tick. The backup counter clears and the lock releases, so no tick is lost.
- R6: The backup counter is 6 bits wide and holds at 63. A tick that arrives while it is full is dropped and sets `ovf_o`, which stays set until reset.
- R7: A transaction that only loads address 0xC5 does not freeze the count. A burst from 0xC5 returns 0x00 for the first byte, then a consistent five-byte count.
- R8: Reads at any address other than 0xC6 leave counting unaffected. Addresses outside 0xC6–0xCA read as 0x00.
- R9: With `presc_en_i` high, one tick is produced for every PRESC_DIV pulses of `osc_i`. The divider holds at zero while `presc_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_i | input | 1 | Oscillator pulse, one clock cycle wide |
| presc_en_i | input | 1 | Route pulses through the divider |
| txn_start_i | input | 1 | Transaction start; loads the pointer |
| txn_end_i | input | 1 | Transaction end; releases the lock |
| addr_i | input | 8 | Start address, sampled with `txn_start_i` |
| rd_i | input | 1 | Read strobe for one byte |
| rdata_o | output | 8 | Registered read byte |
| ovf_o | output | 1 | Sticky backup saturation flag |

## Verification
Bursts from 0xC6 are run with a tick on every cycle and a frozen window swept from 0 to 40 cycles. Each result separates a stalled snapshot from a torn one, and a conserving catch-up from a lossy one. Bursts from 0xC8, from an unrelated address and from 0xC5, plus a setup-only transaction at 0xC5, tell a lock armed by the top-byte strobe apart from one armed by any access. A 70-cycle frozen window tells saturation and a sticky flag apart from wraparound. Divided and undivided pulse trains confirm the tick ratio, and every returned byte is compared against an arithmetic model of the count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned CNT_W_DEF    = 40;
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned ADDR_W_DEF   = 8;
  localparam int unsigned TOP_ADDR_DEF = 'hC6;
  localparam int unsigned TICK_HZ_DEF  = 32768;
  localparam int unsigned HOLD_US_DEF  = 1000;
  localparam int unsigned PRESC_DEF    = 4;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = rtc_pkg::PRESC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!en_i)   div_q <= '0;
    else if (osc_i)   div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
  end

  assign tick_o = osc_i & (~en_i | (div_q == DIV_LAST));

  p_tick_needs_osc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> osc_i);
  p_div_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> div_q == '0);
endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port #(
  parameter int unsigned ADDR_W   = rtc_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W   = rtc_pkg::DATA_W_DEF,
  parameter int unsigned CNT_W    = rtc_pkg::CNT_W_DEF,
  parameter int unsigned TOP_ADDR = rtc_pkg::TOP_ADDR_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              hit_top_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned N_BYTES = CNT_W / DATA_W;

  logic [ADDR_W-1:0]  ptr_q;
  logic [N_BYTES-1:0] byte_hit;
  logic [DATA_W-1:0]  byte_val [N_BYTES];
  logic [DATA_W-1:0]  sel;

  // most significant byte at the lowest address
  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    assign byte_hit[k] = (ptr_q == ADDR_W'(TOP_ADDR + k));
    assign byte_val[k] = cnt_i[CNT_W-1-k*DATA_W -: DATA_W];
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < N_BYTES; k++)
      if (byte_hit[k]) sel = byte_val[k];
  end

  assign hit_top_o = rd_i & byte_hit[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (start_i)   ptr_q <= addr_i;
      else if (rd_i) ptr_q <= ptr_q + 1'b1;
      if (rd_i)      rdata_o <= sel;
    end
  end

  p_ptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !start_i) |=> ptr_q == $past(ptr_q) + 1'b1);
  p_rdata_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int unsigned CNT_W = rtc_pkg::CNT_W_DEF,
  parameter int unsigned BKP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hit_top_i,
  input  logic             end_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [BKP_W-1:0] BKP_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [BKP_W-1:0] bkp_q;
  logic             lock_q, ovf_q, freeze;

  // the strobe cycle itself is already frozen
  assign freeze = lock_q | hit_top_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bkp_q  <= '0;
      lock_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (end_i) begin
      cnt_q  <= cnt_q + CNT_W'(bkp_q) + CNT_W'(tick_i);
      bkp_q  <= '0;
      lock_q <= 1'b0;
    end else if (freeze) begin
      lock_q <= 1'b1;
      if (tick_i) begin
        if (bkp_q == BKP_MAX) ovf_q <= 1'b1;
        else                  bkp_q <= bkp_q + 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(tick_i);
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze && !end_i) |=> $stable(cnt_q));
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> (bkp_q == '0 && !lock_q));
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze && !end_i && tick_i && bkp_q == BKP_MAX) |=> (ovf_q && bkp_q == BKP_MAX));
  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  p_free_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze && !end_i && tick_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/rtc_burst_counter.sv
module rtc_burst_counter #(
  parameter int unsigned CNT_W    = rtc_pkg::CNT_W_DEF,
  parameter int unsigned DATA_W   = rtc_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W   = rtc_pkg::ADDR_W_DEF,
  parameter int unsigned TOP_ADDR = rtc_pkg::TOP_ADDR_DEF,
  parameter int unsigned TICK_HZ  = rtc_pkg::TICK_HZ_DEF,
  parameter int unsigned HOLD_US  = rtc_pkg::HOLD_US_DEF,
  parameter int unsigned PRESC    = rtc_pkg::PRESC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_i,
  input  logic              presc_en_i,
  input  logic              txn_start_i,
  input  logic              txn_end_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ovf_o
);
  // ticks that must fit in the backup during the longest hold window
  localparam int unsigned HOLD_TICKS = (TICK_HZ * HOLD_US + 999_999) / 1_000_000;
  localparam int unsigned BKP_W      = $clog2(HOLD_TICKS + 1);

  logic             tick;
  logic             hit_top;
  logic [CNT_W-1:0] cnt;

  rtc_prescaler #(.DIV(PRESC)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .osc_i (osc_i),
    .en_i  (presc_en_i),
    .tick_o(tick)
  );

  rtc_count_core #(.CNT_W(CNT_W), .BKP_W(BKP_W)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .hit_top_i(hit_top),
    .end_i    (txn_end_i),
    .cnt_o    (cnt),
    .ovf_o    (ovf_o)
  );

  rtc_reg_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .TOP_ADDR(TOP_ADDR)
  ) i_port (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (txn_start_i),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .cnt_i    (cnt),
    .hit_top_o(hit_top),
    .rdata_o  (rdata_o)
  );
endmodule

// File: tb/test_rtc_burst_counter.sv
module test_rtc_burst_counter;
  localparam int DIV = 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0, osc_i = 1'b0, presc_en_i = 1'b0;
  logic       txn_start_i = 1'b0, txn_end_i = 1'b0, rd_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] rdata_o;
  logic       ovf_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference state, derived from the requirements
  logic [39:0] m_cnt = '0;
  int          m_bkp = 0, m_div = 0;
  bit          m_lock = 0, m_ovf = 0;
  logic [7:0]  m_ptr = '0;
  logic [39:0] acc = '0;
  logic [39:0] e_cnt = '0;

  always #10 clk_i = ~clk_i;

  rtc_burst_counter i_rtc_burst_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_i(osc_i), .presc_en_i(presc_en_i),
    .txn_start_i(txn_start_i), .txn_end_i(txn_end_i), .addr_i(addr_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .ovf_o(ovf_o)
  );

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(logic [39:0] c, logic [7:0] p);
    int k;
    if (p < 8'hC6 || p > 8'hCA) return 8'h00;
    k = int'(p) - 'hC6;
    return c[8*(4-k) +: 8];
  endfunction

  task automatic cyc(bit o, bit r, bit s, bit e, logic [7:0] a);
    bit t, hit;
    logic [7:0] eb;
    string tag;
    @(negedge clk_i);
    osc_i = o; rd_i = r; txn_start_i = s; txn_end_i = e; addr_i = a;
    t = 0;
    if (o) begin
      if (!presc_en_i) t = 1;
      else if (m_div == DIV-1) begin t = 1; m_div = 0; end
      else m_div++;
    end
    if (!presc_en_i) m_div = 0;
    hit = r && (m_ptr == 8'hC6);
    eb  = exp_byte(m_cnt, m_ptr);
    tag = (m_ptr >= 8'hC6 && m_ptr <= 8'hCA) ? "R3/R4 byte" : "R8 byte";
    if (e) begin
      m_cnt  = m_cnt + 40'(m_bkp) + 40'(t);
      m_bkp  = 0;
      m_lock = 0;
    end else if (m_lock || hit) begin
      m_lock = 1;
      if (t) begin
        if (m_bkp == 63) m_ovf = 1;
        else m_bkp++;
      end
    end else begin
      m_cnt = m_cnt + 40'(t);
    end
    if (s) m_ptr = a;
    else if (r) m_ptr = m_ptr + 8'd1;
    @(posedge clk_i); #1;
    if (r) begin
      acc = {acc[31:0], rdata_o};
      check(tag, rdata_o, eb);
      check("R6 flag", ovf_o, m_ovf);
    end
  endtask

  task automatic burst(logic [7:0] a, int nrd, int hold, bit o_rd, bit o_end);
    cyc(0, 0, 1, 0, a);
    repeat (nrd) cyc(o_rd, 1, 0, 0, 8'h00);
    repeat (hold) cyc(1, 0, 0, 0, 8'h00);
    cyc(o_end, 0, 0, 1, 8'h00);
  endtask

  task automatic idle(int n, bit o);
    repeat (n) cyc(o, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    check("R1 rdata", rdata_o, 0);
    check("R1 ovf", ovf_o, 0);
    burst(8'hC6, 5, 0, 0, 0);
    check("R1 count", acc, 0);

    idle(37, 1);
    e_cnt = 37;
    burst(8'hC6, 5, 0, 0, 0);
    check("R2 count", acc, e_cnt);

    // R4/R5 sweep of the frozen window, ticking every cycle
    for (int k = 0; k <= 40; k++) begin
      burst(8'hC6, 5, k, 1, 1);
      check("R4 snapshot", acc, e_cnt);
      e_cnt += 40'(5 + k + 1);
    end
    burst(8'hC6, 5, 0, 0, 0);
    check("R5 catch-up", acc, e_cnt);

    burst(8'hC8, 3, 0, 0, 0);
    check("R3 low bytes", acc[23:0], e_cnt[23:0]);

    burst(8'h10, 3, 0, 1, 1);
    check("R8 unmapped reads", acc[23:0], 0);
    e_cnt += 4;
    burst(8'hC8, 3, 0, 1, 1);
    e_cnt += 4;
    burst(8'hC6, 5, 0, 0, 0);
    check("R8 counting kept", acc, e_cnt);

    cyc(0, 0, 1, 0, 8'hC5);
    idle(10, 1);
    cyc(1, 0, 0, 1, 8'h00);
    e_cnt += 11;
    burst(8'hC5, 6, 0, 0, 0);
    check("R7 setup only", acc, e_cnt);
    burst(8'hC5, 6, 0, 1, 0);
    check("R7 burst from C5", acc, e_cnt + 1);
    e_cnt += 6;

    check("R6 flag clear", ovf_o, 0);
    burst(8'hC6, 5, 70, 1, 0);
    e_cnt += 63;
    check("R6 flag set", ovf_o, 1);
    burst(8'hC6, 5, 0, 0, 0);
    check("R6 saturated", acc, e_cnt);
    check("R6 sticky", ovf_o, 1);

    presc_en_i = 1'b1;
    idle(23, 1);
    presc_en_i = 1'b0;
    e_cnt += 5;
    burst(8'hC6, 5, 0, 0, 0);
    check("R9 divide", acc, e_cnt);
    presc_en_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cyc(1, 0, 0, 0, 8'h00);
      cyc(0, 0, 0, 0, 8'h00);
    end
    presc_en_i = 1'b0;
    e_cnt += 2;
    burst(8'hC6, 5, 0, 0, 0);
    check("R9 gapped pulses", acc, e_cnt);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule